// File: doc/BRIEF.md
# Punched Card Deck Loader Engine

This block is a bootstrap sequencer. It pulls a program deck, one card image at a time, from a card-reader style word source and places the program into a word-addressed memory. Each card image is ten 48-bit words. A word holds eight 6-bit characters, and character 0 is the most significant. The engine asks for a card and captures the words as they arrive. It then takes a completion status. The last word of the card is a control word. The engine reads a destination address and a payload count from it, writes the payload words into memory, and asks for the next card.

The address and the count are written on the card as octal digit characters. A digit character's code equals its binary value, so the engine builds each number by keeping the low three bits of every character and joining them together. A read-check error in the status stops the engine for good. Other status conditions are ignored, so a card that never arrived causes the previous buffer to be copied again.

An end-of-deck status starts a final relocation. The engine moves a fixed block of words downward by the load bias, one read and one write per word. It then pulses a done output and presents the program start address.

Top module: `deck_loader`

## Requirements
- R1: While reset is held, card_req, mem_en, err_halt, load_done and start_vld are all low. The first card request (card_req high) follows within three cycles of reset release.
- R2: Card words captured during a request fill buffer slots 0, 1, 2, ... in arrival order. A slot that receives no word keeps its previous contents. Slot 0 is never written to memory.
- R3: The destination address is built from characters 3 to 7 of the control word (slot 9), with character 7 as the least significant octal digit. Each character contributes its bits [2:0]; its bits [5:3] are ignored. The 15-bit result is the first write address.
- R4: The payload count is (bit 0 of character 1) × 8 + (bits [2:0] of character 2). A value above 8 is clamped to 8. All other bits of characters 0 to 2 are ignored, and no write burst is longer than 8 cycles.
- R5: Slots 1..N are written on consecutive cycles to addresses A, A+1, ... A+N-1, with the address wrapping modulo 2^15. The memory is not accessed while a card is being requested.
- R6: A decoded count of zero causes no memory write, and card_req returns two cycles after the status.
- R7: Status bit 0 (read-check) drives err_halt high permanently. After that the engine issues no request, no memory access and no done pulse. This bit takes priority over status bit 2.
- R8: All other status bits, such as bit 1 (reader not ready), are ignored. A not-ready card with no words copies the buffer unchanged, using its old control word.
- R9: Status bit 2 (end of deck), when bit 0 is clear, skips the card's copy and relocates 3969 words. For k = 0, 1, ... in order, the engine reads word 112+k and then writes that value to word 16+k.
- R10: One cycle after the last relocation write, load_done is high for exactly one cycle. start_vld then stays high with start_addr = 16, and no further requests or memory accesses occur.
- R11: After a non-zero copy, card_req rises again in the cycle after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_req | output | 1 | High while the engine waits for a card and its status |
| card_vld | input | 1 | A card word is presented |
| card_data | input | 48 | Card word, in slot order |
| stat_vld | input | 1 | Completion status is presented; ends the card |
| stat_code | input | 8 | Status: bit 0 read-check, bit 1 not ready, bit 2 end of deck |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 48 | Write data |
| mem_rdata | input | 48 | Read data, one cycle after a read access |
| err_halt | output | 1 | Permanent read-check halt |
| load_done | output | 1 | One-cycle pulse when relocation completes |
| start_vld | output | 1 | Load finished; start address is valid |
| start_addr | output | 15 | Program start word address |

## Verification
Any error in decoding or sequencing reaches the memory port within one cycle. A wrong address, count or slot shows up as a write that differs from the expected write queue on that clock, or as a write the queue did not expect. A lost or stuck capture index shows up on the next card, because its copy carries stale or misplaced words. A relocation counter that is off by one moves the whole write stream, which is caught on the first relocation write, and it also shifts the time of the done pulse.

// File: rtl/deck_loader_pkg.sv
package deck_loader_pkg;
   localparam int DIG_BITS = 3;

   typedef enum logic [3:0] {
      ST_BOOT,
      ST_REQ,
      ST_DECODE,
      ST_COPY,
      ST_RELOC_RD,
      ST_RELOC_WR,
      ST_FIN,
      ST_DONE,
      ST_HALT
   } ld_state_e;
endpackage

// File: rtl/deck_card_buffer.sv
module deck_card_buffer #(
   parameter int WORD_W     = 48,
   parameter int CARD_WORDS = 10,
   localparam int IDX_W     = $clog2(CARD_WORDS)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cap_en,
   input  logic                                 restart,
   input  logic [WORD_W-1:0]                    cap_data,
   output logic [CARD_WORDS-1:0][WORD_W-1:0]    words
);
   logic [IDX_W-1:0] idx_q;
   logic             full_q;
   logic             take;

   assign take = cap_en && !full_q;

   // arrival index; extra words beyond the card are dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         full_q <= 1'b0;
      end else if (restart) begin
         idx_q  <= '0;
         full_q <= 1'b0;
      end else if (take) begin
         if (idx_q == IDX_W'(CARD_WORDS - 1)) begin
            full_q <= 1'b1;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   // one register per slot; a slot keeps its value until overwritten
   for (genvar g = 0; g < CARD_WORDS; g++) begin : g_slot
      logic [WORD_W-1:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
         end else if (take && (idx_q == IDX_W'(g))) begin
            w_q <= cap_data;
         end
      end
      assign words[g] = w_q;
   end
endmodule

// File: rtl/deck_ctl_decode.sv
module deck_ctl_decode
   import deck_loader_pkg::*;
#(
   parameter int WORD_W     = 48,
   parameter int CHAR_W     = 6,
   parameter int ADDR_W     = 15,
   parameter int ADDR_CHARS = 5,
   parameter int MAX_PAY    = 8,
   localparam int CNT_W     = $clog2(MAX_PAY + 1),
   localparam int PK_W      = ADDR_CHARS * DIG_BITS,
   localparam int RAW_W     = 1 + DIG_BITS
) (
   input  logic [WORD_W-1:0] ctl_word,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [CNT_W-1:0]  pay_cnt
);
   logic [PK_W-1:0]  packed_addr;
   logic [RAW_W-1:0] cnt_raw;
   logic             unused_ctl;

   // digit d sits in the d-th character from the least significant end
   for (genvar d = 0; d < ADDR_CHARS; d++) begin : g_digit
      assign packed_addr[d*DIG_BITS +: DIG_BITS] = ctl_word[d*CHAR_W +: DIG_BITS];
   end

   if (PK_W > ADDR_W) begin : g_trunc
      assign dst_addr = packed_addr[ADDR_W-1:0];
   end else begin : g_exact
      assign dst_addr = ADDR_W'(packed_addr);
   end

   // count: low bit of character 1, low three bits of character 2
   assign cnt_raw = {ctl_word[WORD_W - 2*CHAR_W],
                     ctl_word[WORD_W - 3*CHAR_W +: DIG_BITS]};

   always_comb begin
      if (cnt_raw > RAW_W'(MAX_PAY)) begin
         pay_cnt = CNT_W'(MAX_PAY);
      end else begin
         pay_cnt = CNT_W'(cnt_raw);
      end
   end

   assign unused_ctl = ^ctl_word;
endmodule

// File: rtl/deck_loader_fsm.sv
module deck_loader_fsm
   import deck_loader_pkg::*;
#(
   parameter int WORD_W      = 48,
   parameter int CARD_WORDS  = 10,
   parameter int ADDR_W      = 15,
   parameter int MAX_PAY     = 8,
   parameter int STAT_W      = 8,
   parameter int RDCHK_BIT   = 0,
   parameter int EOD_BIT     = 2,
   parameter int RELOC_SRC   = 112,
   parameter int RELOC_DST   = 16,
   parameter int RELOC_WORDS = 3969,
   localparam int CNT_W      = $clog2(MAX_PAY + 1),
   localparam int IDX_W      = $clog2(CARD_WORDS),
   localparam int K_W        = $clog2(RELOC_WORDS + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              card_vld,
   input  logic                              stat_vld,
   input  logic [STAT_W-1:0]                 stat_code,
   input  logic [ADDR_W-1:0]                 dec_addr,
   input  logic [CNT_W-1:0]                  dec_cnt,
   input  logic [CARD_WORDS-1:0][WORD_W-1:0] words,
   input  logic [WORD_W-1:0]                 mem_rdata,
   output logic                              card_req,
   output logic                              cap_en,
   output logic                              cap_restart,
   output logic                              mem_en,
   output logic                              mem_we,
   output logic [ADDR_W-1:0]                 mem_addr,
   output logic [WORD_W-1:0]                 mem_wdata,
   output logic                              err_halt,
   output logic                              load_done,
   output logic                              start_vld
);
   ld_state_e         st_q, st_d;
   logic [ADDR_W-1:0] dst_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  ci_q;
   logic [K_W-1:0]    k_q;
   logic [IDX_W-1:0]  slot_sel;
   logic              copy_last;
   logic              reloc_last;
   logic              unused_stat;

   assign copy_last  = (ci_q == cnt_q - CNT_W'(1));
   assign reloc_last = (k_q == K_W'(RELOC_WORDS - 1));
   assign slot_sel   = IDX_W'(ci_q) + IDX_W'(1);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_BOOT:     st_d = ST_REQ;
         ST_REQ: begin
            if (stat_vld) begin
               if (stat_code[RDCHK_BIT])     st_d = ST_HALT;
               else if (stat_code[EOD_BIT])  st_d = ST_RELOC_RD;
               else                          st_d = ST_DECODE;
            end
         end
         ST_DECODE:   st_d = (dec_cnt == '0) ? ST_REQ : ST_COPY;
         ST_COPY:     st_d = copy_last ? ST_REQ : ST_COPY;
         ST_RELOC_RD: st_d = ST_RELOC_WR;
         ST_RELOC_WR: st_d = reloc_last ? ST_FIN : ST_RELOC_RD;
         ST_FIN:      st_d = ST_DONE;
         ST_DONE:     st_d = ST_DONE;
         ST_HALT:     st_d = ST_HALT;
         default:     st_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_BOOT;
         dst_q <= '0;
         cnt_q <= '0;
         ci_q  <= '0;
         k_q   <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            ST_REQ: begin
               k_q <= '0;
            end
            ST_DECODE: begin
               dst_q <= dec_addr;
               cnt_q <= dec_cnt;
               ci_q  <= '0;
            end
            ST_COPY: begin
               ci_q <= ci_q + CNT_W'(1);
            end
            ST_RELOC_WR: begin
               k_q <= k_q + K_W'(1);
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st_q)
         ST_COPY: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_q + ADDR_W'(ci_q);
            mem_wdata = words[slot_sel];
         end
         ST_RELOC_RD: begin
            mem_en   = 1'b1;
            mem_addr = ADDR_W'(RELOC_SRC) + ADDR_W'(k_q);
         end
         ST_RELOC_WR: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ADDR_W'(RELOC_DST) + ADDR_W'(k_q);
            mem_wdata = mem_rdata;
         end
         default: ;
      endcase
   end

   assign card_req    = (st_q == ST_REQ);
   assign cap_en      = card_req && card_vld;
   assign cap_restart = card_req && stat_vld;
   assign err_halt    = (st_q == ST_HALT);
   assign load_done   = (st_q == ST_FIN);
   assign start_vld   = (st_q == ST_DONE);
   assign unused_stat = ^stat_code;
endmodule

// File: rtl/deck_loader.sv
module deck_loader
   import deck_loader_pkg::*;
#(
   parameter int WORD_W      = 48,
   parameter int CHAR_W      = 6,
   parameter int CARD_WORDS  = 10,
   parameter int ADDR_W      = 15,
   parameter int ADDR_CHARS  = 5,
   parameter int MAX_PAY     = 8,
   parameter int STAT_W      = 8,
   parameter int RDCHK_BIT   = 0,
   parameter int EOD_BIT     = 2,
   parameter int RELOC_SRC   = 112,
   parameter int RELOC_DST   = 16,
   parameter int RELOC_WORDS = 3969,
   parameter int START_ADDR  = 16,
   localparam int NCHARS     = WORD_W / CHAR_W,
   localparam int CNT_W      = $clog2(MAX_PAY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              card_req,
   input  logic              card_vld,
   input  logic [WORD_W-1:0] card_data,
   input  logic              stat_vld,
   input  logic [STAT_W-1:0] stat_code,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              err_halt,
   output logic              load_done,
   output logic              start_vld,
   output logic [ADDR_W-1:0] start_addr
);
   // elaboration-time parameter checks
   if (WORD_W % CHAR_W != 0) begin : g_bad_char
      $error("WORD_W must be a whole number of characters");
   end
   if (ADDR_CHARS * DIG_BITS < ADDR_W) begin : g_bad_addr
      $error("address characters too few for ADDR_W");
   end
   if (ADDR_CHARS > NCHARS - 3) begin : g_bad_layout
      $error("address characters overlap the count field");
   end
   if (MAX_PAY > CARD_WORDS - 2 || MAX_PAY < 1) begin : g_bad_pay
      $error("MAX_PAY must fit between the first and last card words");
   end
   if (RDCHK_BIT >= STAT_W || EOD_BIT >= STAT_W || RDCHK_BIT == EOD_BIT) begin : g_bad_stat
      $error("status bit positions invalid");
   end
   if (RELOC_WORDS < 1) begin : g_bad_reloc
      $error("RELOC_WORDS must be at least 1");
   end

   logic [CARD_WORDS-1:0][WORD_W-1:0] words;
   logic [ADDR_W-1:0]                 dec_addr;
   logic [CNT_W-1:0]                  dec_cnt;
   logic                              cap_en;
   logic                              cap_restart;

   deck_card_buffer #(
      .WORD_W    (WORD_W),
      .CARD_WORDS(CARD_WORDS)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .restart (cap_restart),
      .cap_data(card_data),
      .words   (words)
   );

   deck_ctl_decode #(
      .WORD_W    (WORD_W),
      .CHAR_W    (CHAR_W),
      .ADDR_W    (ADDR_W),
      .ADDR_CHARS(ADDR_CHARS),
      .MAX_PAY   (MAX_PAY)
   ) u_dec (
      .ctl_word(words[CARD_WORDS-1]),
      .dst_addr(dec_addr),
      .pay_cnt (dec_cnt)
   );

   deck_loader_fsm #(
      .WORD_W     (WORD_W),
      .CARD_WORDS (CARD_WORDS),
      .ADDR_W     (ADDR_W),
      .MAX_PAY    (MAX_PAY),
      .STAT_W     (STAT_W),
      .RDCHK_BIT  (RDCHK_BIT),
      .EOD_BIT    (EOD_BIT),
      .RELOC_SRC  (RELOC_SRC),
      .RELOC_DST  (RELOC_DST),
      .RELOC_WORDS(RELOC_WORDS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .card_vld   (card_vld),
      .stat_vld   (stat_vld),
      .stat_code  (stat_code),
      .dec_addr   (dec_addr),
      .dec_cnt    (dec_cnt),
      .words      (words),
      .mem_rdata  (mem_rdata),
      .card_req   (card_req),
      .cap_en     (cap_en),
      .cap_restart(cap_restart),
      .mem_en     (mem_en),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .err_halt   (err_halt),
      .load_done  (load_done),
      .start_vld  (start_vld)
   );

   assign start_addr = ADDR_W'(START_ADDR);
endmodule

// File: rtl/deck_loader_chk.sv
module deck_loader_chk #(
   parameter int MAX_PAY = 8
) (
   input logic clk,
   input logic rst_n,
   input logic card_req,
   input logic mem_en,
   input logic mem_we,
   input logic err_halt,
   input logic load_done,
   input logic start_vld
);
   localparam int RUN_W = $clog2(MAX_PAY + 2);
   logic [RUN_W-1:0] run_q;

   // length of the current run of back-to-back writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (mem_en && mem_we) begin
         if (run_q != RUN_W'(MAX_PAY + 1)) run_q <= run_q + RUN_W'(1);
      end else begin
         run_q <= '0;
      end
   end

   p_burst_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (run_q < RUN_W'(MAX_PAY)));

   p_req_mem_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_req && mem_en));

   p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_halt |-> (!card_req && !mem_en && !load_done && !start_vld));

   p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_halt |=> err_halt);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> (!load_done && start_vld));

   p_start_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_vld |=> (start_vld && !card_req && !mem_en));
endmodule

bind deck_loader deck_loader_chk #(.MAX_PAY(MAX_PAY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .card_req (card_req),
   .mem_en   (mem_en),
   .mem_we   (mem_we),
   .err_halt (err_halt),
   .load_done(load_done),
   .start_vld(start_vld)
);

// File: tb/tb_deck_loader.sv
module tb_deck_loader;
   localparam int CLK_PERIOD = 10;
   localparam int RAM_N      = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        card_req;
   logic        card_vld = 1'b0;
   logic [47:0] card_data = '0;
   logic        stat_vld = 1'b0;
   logic [7:0]  stat_code = '0;
   logic        mem_en, mem_we;
   logic [14:0] mem_addr;
   logic [47:0] mem_wdata;
   logic [47:0] mem_rdata = '0;
   logic        err_halt, load_done, start_vld;
   logic [14:0] start_addr;

   deck_loader dut (
      .clk(clk), .rst_n(rst_n), .card_req(card_req), .card_vld(card_vld),
      .card_data(card_data), .stat_vld(stat_vld), .stat_code(stat_code),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .err_halt(err_halt),
      .load_done(load_done), .start_vld(start_vld), .start_addr(start_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int done_cnt = 0;
   bit finished = 0;

   logic [47:0] ram    [RAM_N];
   logic [47:0] shadow [RAM_N];
   logic [47:0] tb_buf [10];
   logic [47:0] cw     [10];
   int          expa[$];
   logic [47:0] expd[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // synchronous single-port memory
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[int'(mem_addr) % RAM_N] <= mem_wdata;
         else        mem_rdata <= ram[int'(mem_addr) % RAM_N];
      end
   end

   // every clock: any write must match the head of the expected stream
   always @(negedge clk) begin
      if (rst_n && mem_en && mem_we) begin
         if (expa.size() == 0) begin
            chk(1'b0, "R6", "unexpected write addr", 64'(mem_addr), 64'hFFFF);
         end else begin
            int          ea;
            logic [47:0] ed;
            ea = expa.pop_front();
            ed = expd.pop_front();
            chk(int'(mem_addr) == ea, "R5", "write address", 64'(mem_addr), 64'(ea));
            chk(mem_wdata == ed, "R5", "write data", 64'(mem_wdata), 64'(ed));
         end
      end
      if (rst_n && load_done) done_cnt++;
   end

   function automatic logic [5:0] ch(input logic [47:0] w, input int i);
      return w[47 - 6*i -: 6];
   endfunction

   // build a control word; junk goes into the upper three bits of each character
   function automatic logic [47:0] mk_ctl(input int cnt, input int addr, input logic [2:0] junk);
      logic [47:0] w;
      w = '0;
      w[47 -: 6] = {junk, 3'd5};
      w[41 -: 6] = {junk, 3'(cnt / 8)};
      w[35 -: 6] = {junk, 3'(cnt % 8)};
      for (int d = 0; d < 5; d++) w[6*d +: 6] = {junk, 3'((addr >> (3*d)) & 7)};
      return w;
   endfunction

   // reference model of one card: update buffer and queue the expected writes
   task automatic model_card(input int n, input logic [7:0] st);
      int a, c;
      for (int i = 0; i < n && i < 10; i++) tb_buf[i] = cw[i];
      if (st[0]) return;
      if (st[2]) begin
         for (int k = 0; k < 3969; k++) begin
            expa.push_back(16 + k);
            expd.push_back(shadow[112 + k]);
            shadow[16 + k] = shadow[112 + k];
         end
         return;
      end
      c = (int'(ch(tb_buf[9], 1)) & 1) * 8 + (int'(ch(tb_buf[9], 2)) & 7);
      if (c > 8) c = 8;
      a = 0;
      for (int d = 0; d < 5; d++) a += (int'(ch(tb_buf[9], 7 - d)) & 7) << (3*d);
      a = a & 32'h7FFF;
      for (int i = 0; i < c; i++) begin
         expa.push_back((a + i) & 32'h7FFF);
         expd.push_back(tb_buf[1 + i]);
         shadow[((a + i) & 32'h7FFF) % RAM_N] = tb_buf[1 + i];
      end
   endtask

   task automatic send_card(input int n, input logic [7:0] st);
      model_card(n, st);
      @(negedge clk);
      while (!card_req) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         card_vld  = 1'b1;
         card_data = cw[i];
         @(negedge clk);
      end
      card_vld  = 1'b0;
      stat_vld  = 1'b1;
      stat_code = st;
      @(negedge clk);
      stat_vld  = 1'b0;
      stat_code = '0;
   endtask

   // wait for the copy to finish and the next request (R11)
   task automatic settle(input string req);
      int t;
      t = 0;
      while (!(card_req && expa.size() == 0) && t < 40) begin
         @(negedge clk);
         t++;
      end
      chk(card_req == 1'b1, req, "next request after copy", 64'(card_req), 64'd1);
      chk(expa.size() == 0, req, "pending writes", 64'(expa.size()), 64'd0);
   endtask

   task automatic fill_payload(input int seed);
      for (int i = 0; i < 9; i++) cw[i] = {16'hC0DE, 32'(seed * 100 + i)};
   endtask

   task automatic check_reset_outs;
      chk(card_req == 0, "R1", "card_req in reset", 64'(card_req), 0);
      chk(mem_en == 0, "R1", "mem_en in reset", 64'(mem_en), 0);
      chk(err_halt == 0, "R1", "err_halt in reset", 64'(err_halt), 0);
      chk(load_done == 0 && start_vld == 0, "R1", "done/start in reset",
          64'({load_done, start_vld}), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < RAM_N; i++) begin
         ram[i]    = {16'hA5A5, 32'(i * 7 + 3)};
         shadow[i] = {16'hA5A5, 32'(i * 7 + 3)};
      end
      for (int i = 0; i < 10; i++) tb_buf[i] = '0;

      repeat (3) @(negedge clk);
      check_reset_outs();                                   // R1
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(card_req == 1, "R1", "first request after reset", 64'(card_req), 1);

      // full card, count 8 at octal 200 (R2, R3, R5)
      fill_payload(1);
      cw[9] = mk_ctl(8, 'o200, 3'b000);
      send_card(10, 8'h00);
      settle("R11");

      // upper character bits set, wrap at top of address space (R3, R4, R5)
      fill_payload(2);
      cw[9] = mk_ctl(3, 'o77776, 3'b111);
      send_card(10, 8'h00);
      settle("R3");

      // count zero: no writes, request in two cycles (R6)
      fill_payload(3);
      cw[9] = mk_ctl(0, 'o4000, 3'b010);
      model_card(10, 8'h00);
      @(negedge clk);
      while (!card_req) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         card_vld = 1'b1; card_data = cw[i]; @(negedge clk);
      end
      card_vld = 1'b0; stat_vld = 1'b1; @(negedge clk); stat_vld = 1'b0;
      chk(card_req == 0, "R6", "request drops after status", 64'(card_req), 0);
      @(negedge clk);
      chk(card_req == 1, "R6", "request two cycles after status", 64'(card_req), 1);
      chk(expa.size() == 0, "R6", "no writes for zero count", 64'(expa.size()), 0);

      // count field 17 octal clamps to 8 (R4)
      fill_payload(4);
      cw[9] = mk_ctl(15, 'o1000, 3'b000);
      send_card(10, 8'h00);
      settle("R4");

      // not ready with no words: old buffer copied again (R8)
      send_card(0, 8'h02);
      settle("R8");

      // partial card: only first four slots replaced (R2)
      for (int i = 0; i < 4; i++) cw[i] = {16'hBEEF, 32'(i)};
      send_card(4, 8'h00);
      settle("R2");

      // end of deck: card not copied, relocation follows (R9, R10)
      fill_payload(5);
      cw[9] = mk_ctl(8, 'o300, 3'b000);
      send_card(10, 8'h04);
      for (int t = 0; t < 20000 && !start_vld; t++) @(negedge clk);
      chk(start_vld == 1, "R10", "start valid after relocation", 64'(start_vld), 1);
      chk(start_addr == 15'd16, "R10", "start address", 64'(start_addr), 16);
      chk(expa.size() == 0, "R9", "relocation writes outstanding", 64'(expa.size()), 0);
      repeat (5) @(negedge clk);
      chk(done_cnt == 1, "R10", "done pulse count", 64'(done_cnt), 1);
      chk(card_req == 0 && mem_en == 0, "R10", "idle after done",
          64'({card_req, mem_en}), 0);

      // second run: read-check with end-of-deck set halts (R7)
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_outs();
      rst_n = 1'b1;
      fill_payload(6);
      cw[9] = mk_ctl(8, 'o500, 3'b000);
      send_card(10, 8'h05);
      repeat (40) @(negedge clk);
      chk(err_halt == 1, "R7", "halt after read-check", 64'(err_halt), 1);
      chk(card_req == 0, "R7", "no request when halted", 64'(card_req), 0);
      chk(start_vld == 0 && done_cnt == 1, "R7", "no done when halted",
          64'({start_vld, 8'(done_cnt)}), 1);
      chk(expa.size() == 0, "R7", "no writes expected", 64'(expa.size()), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule